// File: doc/BRIEF.md
# Cache-Side Directory Coherence Controller

This block is the coherence engine placed beside one small direct-mapped cache in a system where a home directory, not a shared bus, keeps track of which caches hold each memory block. Each line holds one of three states: Invalid, Shared (a read-only copy, memory up to date) or Exclusive (this cache owns the block and may have changed it). CPU requests that hit finish locally. Requests that miss produce a read-miss or write-miss message to the directory, and the processor is held until the data reply arrives. A write to a Shared line counts as a write miss, so that the directory can revoke the other copies.

The directory can also send three commands: invalidate a Shared copy, fetch an Exclusive copy (the line is written back and kept as Shared), and fetch-and-invalidate (the line is written back and dropped). When a miss would evict a different block held Exclusive, the old block is first written back. The new request goes out in the next cycle. A Shared victim is overwritten with no message.

The control sequencer has three states. IDLE completes hits. On a miss it moves to MISS. MISS sends a write-back for a dirty victim and stays in MISS, or sends the request and moves to WAIT. WAIT installs the matching data reply and returns to IDLE, where the held request is replayed and then completes as a hit. In every state a directory command takes priority over local work in that cycle, and local work waits one cycle.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_stall` and `msg_valid` are low, and the first access to any address misses.
- R2: A read to an Invalid line (or to a line holding another tag) sends `msg_kind`=0 (read miss) with the block address `cpu_addr[AD_W-1:OFF_W]`. The line becomes Shared, and the read returns the replied word. Word k of a block sits at bits [k*WORD_W +: WORD_W], and the word is selected by `cpu_addr[OFF_W-1:0]`.
- R3: A write to an Invalid or Shared line sends `msg_kind`=1 (write miss). The written word is merged into the replied block, the other words keep the replied values, and the line becomes Exclusive.
- R4: Read hits on Shared or Exclusive lines, and write hits on Exclusive lines, send no message and complete in the same cycle the request is presented.
- R5: A directory invalidate (`dir_kind`=0) for a Shared line with a matching tag makes the line Invalid, with no message.
- R6: A directory fetch (`dir_kind`=1) for a matching Exclusive line sends a write-back (`msg_kind`=2) carrying the line data, and leaves the line Shared.
- R7: A directory fetch-and-invalidate (`dir_kind`=2) for a matching Exclusive line sends a write-back with the line data and makes the line Invalid.
- R8: A miss whose line holds a different block in Exclusive sends that block's write-back first and the miss message in the next cycle. A Shared victim is replaced without a write-back.
- R9: `cpu_stall` is high from the cycle a missing request is presented until the cycle it completes. A miss completes 3 cycles after the request when the reply arrives in the cycle after the miss message, plus one cycle for a victim write-back and one for each cycle of extra reply delay.
- R10: Directory commands whose address does not match the stored tag (or whose state does not match), and data replies (`dir_kind`=3) that arrive when no miss is pending, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AD_W | Word address {tag, index, word offset} |
| cpu_wdata | input | WORD_W | Write word |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_done` |
| cpu_done | output | 1 | Access completes at this clock edge |
| cpu_stall | output | 1 | Request pending and not completing |
| msg_valid | output | 1 | Message to the directory this cycle |
| msg_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_addr | output | BA_W | Block address of the message |
| msg_blk | output | BLK_W | Block data (write-back only) |
| dir_valid | input | 1 | Message from the directory this cycle |
| dir_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| dir_addr | input | BA_W | Block address |
| dir_blk | input | BLK_W | Reply data |

## Verification
A line left in the wrong state shows up at the message port at the next access or directory command for that line. A line wrongly kept Exclusive answers a fetch with a write-back where none is due. A line wrongly left Shared stays silent on a write and produces no write miss. A line wrongly kept valid hits in zero cycles where a miss message was expected. A sequencer stuck in MISS or WAIT keeps `cpu_stall` high past the expected completion cycle, and a stale data word appears in the write-back payload or the read word on the next access to that block.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CF_IDLE = 2'd0,
        CF_MISS = 2'd1,
        CF_WAIT = 2'd2
    } ctl_st_e;

    // outgoing message kinds
    localparam logic [1:0] OUT_RD = 2'd0;
    localparam logic [1:0] OUT_WR = 2'd1;
    localparam logic [1:0] OUT_WB = 2'd2;

    // incoming directory kinds
    localparam logic [1:0] IN_INV      = 2'd0;
    localparam logic [1:0] IN_FETCH    = 2'd1;
    localparam logic [1:0] IN_FETCHINV = 2'd2;
    localparam logic [1:0] IN_DATA     = 2'd3;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int IDX_W = 2,
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_e         a_st,
    output logic [TAG_W-1:0] a_tag,
    output logic [BLK_W-1:0] a_blk,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_e         b_st,
    output logic [TAG_W-1:0] b_tag,
    output logic [BLK_W-1:0] b_blk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_e         wr_st,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_blk
);
    localparam int NLINES = 1 << IDX_W;

    line_st_e         st_q  [NLINES];
    logic [TAG_W-1:0] tag_q [NLINES];
    logic [BLK_W-1:0] blk_q [NLINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
                blk_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]  <= wr_st;
            tag_q[wr_idx] <= wr_tag;
            blk_q[wr_idx] <= wr_blk;
        end
    end

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign a_blk = blk_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];
    assign b_blk = blk_q[b_idx];

endmodule

// File: rtl/coh_tag_match.sv
module coh_tag_match
    import coh_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  line_st_e         st,
    input  logic [TAG_W-1:0] have_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             present,
    output logic             owned
);
    logic same;
    assign same    = (have_tag == want_tag);
    assign present = same && (st != LS_INV);
    assign owned   = same && (st == LS_EXC);
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int WORD_W = 8,
    localparam int WORDS = 1 << OFF_W,
    localparam int BLK_W = WORDS * WORD_W,
    localparam int BA_W  = TAG_W + IDX_W,
    localparam int AD_W  = BA_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AD_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [BA_W-1:0]   msg_addr,
    output logic [BLK_W-1:0]  msg_blk,
    input  logic              dir_valid,
    input  logic [1:0]        dir_kind,
    input  logic [BA_W-1:0]   dir_addr,
    input  logic [BLK_W-1:0]  dir_blk
);
    // address fields
    logic [TAG_W-1:0] c_tag, d_tag;
    logic [IDX_W-1:0] c_idx, d_idx;
    logic [OFF_W-1:0] c_off;
    logic [BA_W-1:0]  c_baddr;

    assign c_tag   = cpu_addr[AD_W-1 -: TAG_W];
    assign c_idx   = cpu_addr[OFF_W +: IDX_W];
    assign c_off   = cpu_addr[OFF_W-1:0];
    assign c_baddr = cpu_addr[AD_W-1:OFF_W];
    assign d_tag   = dir_addr[BA_W-1 -: TAG_W];
    assign d_idx   = dir_addr[IDX_W-1:0];

    // line store
    line_st_e         a_st, b_st, wr_st;
    logic [TAG_W-1:0] a_tag, b_tag, wr_tag;
    logic [BLK_W-1:0] a_blk, b_blk, wr_blk;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    coh_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .BLK_W(BLK_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_blk(a_blk),
        .b_idx(d_idx), .b_st(b_st), .b_tag(b_tag), .b_blk(b_blk),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
        .wr_tag(wr_tag), .wr_blk(wr_blk)
    );

    logic a_present, a_owned, b_present, b_owned;

    coh_tag_match #(.TAG_W(TAG_W)) cpu_match_i (
        .st(a_st), .have_tag(a_tag), .want_tag(c_tag),
        .present(a_present), .owned(a_owned)
    );
    coh_tag_match #(.TAG_W(TAG_W)) dir_match_i (
        .st(b_st), .have_tag(b_tag), .want_tag(d_tag),
        .present(b_present), .owned(b_owned)
    );

    // word selection and merging
    logic [WORD_W-1:0] a_words [WORDS];
    logic [BLK_W-1:0]  hit_blk, mrg_blk;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic sel;
        assign sel          = cpu_we && (c_off == OFF_W'(w));
        assign a_words[w]   = a_blk[w*WORD_W +: WORD_W];
        assign hit_blk[w*WORD_W +: WORD_W] = sel ? cpu_wdata : a_blk[w*WORD_W +: WORD_W];
        assign mrg_blk[w*WORD_W +: WORD_W] = sel ? cpu_wdata : dir_blk[w*WORD_W +: WORD_W];
    end

    assign cpu_rdata = a_words[c_off];

    // decode
    logic coh_act, cpu_hit, victim_dirty, reply_ok;
    assign coh_act      = dir_valid && (dir_kind != IN_DATA);
    assign cpu_hit      = cpu_we ? a_owned : a_present;
    assign victim_dirty = (a_st == LS_EXC) && (a_tag != c_tag);
    assign reply_ok     = dir_valid && (dir_kind == IN_DATA) && (dir_addr == c_baddr);
    assign wr_idx       = coh_act ? d_idx : c_idx;

    // sequencer
    ctl_st_e fsm_q, fsm_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= CF_IDLE;
        else        fsm_q <= fsm_d;
    end

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            CF_IDLE: if (cpu_req && !coh_act && !cpu_hit) fsm_d = CF_MISS;
            CF_MISS: if (!coh_act && !victim_dirty)       fsm_d = CF_WAIT;
            CF_WAIT: if (reply_ok)                        fsm_d = CF_IDLE;
            default: fsm_d = CF_IDLE;
        endcase
    end

    always_comb begin
        cpu_done  = 1'b0;
        msg_valid = 1'b0;
        msg_kind  = OUT_RD;
        msg_addr  = '0;
        msg_blk   = '0;
        wr_en     = 1'b0;
        wr_st     = LS_INV;
        wr_tag    = a_tag;
        wr_blk    = a_blk;
        if (coh_act) begin
            // directory command wins this cycle
            wr_tag = b_tag;
            wr_blk = b_blk;
            if (dir_kind == IN_INV) begin
                if (b_present && b_st == LS_SHR) begin
                    wr_en = 1'b1;
                    wr_st = LS_INV;
                end
            end else if (b_owned) begin
                msg_valid = 1'b1;
                msg_kind  = OUT_WB;
                msg_addr  = dir_addr;
                msg_blk   = b_blk;
                wr_en     = 1'b1;
                wr_st     = (dir_kind == IN_FETCH) ? LS_SHR : LS_INV;
            end
        end else begin
            unique case (fsm_q)
                CF_IDLE: begin
                    if (cpu_req && cpu_hit) begin
                        cpu_done = 1'b1;
                        if (cpu_we) begin
                            wr_en  = 1'b1;
                            wr_st  = LS_EXC;
                            wr_blk = hit_blk;
                        end
                    end
                end
                CF_MISS: begin
                    msg_valid = 1'b1;
                    if (victim_dirty) begin
                        msg_kind = OUT_WB;
                        msg_addr = {a_tag, c_idx};
                        msg_blk  = a_blk;
                        wr_en    = 1'b1;
                        wr_st    = LS_INV;
                    end else begin
                        msg_kind = cpu_we ? OUT_WR : OUT_RD;
                        msg_addr = c_baddr;
                    end
                end
                CF_WAIT: begin
                    if (reply_ok) begin
                        wr_en  = 1'b1;
                        wr_st  = cpu_we ? LS_EXC : LS_SHR;
                        wr_tag = c_tag;
                        wr_blk = mrg_blk;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cpu_stall = cpu_req && !cpu_done;

    // assertions
    p_req_before_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == CF_WAIT && $past(fsm_q) == CF_MISS)
        |-> $past(msg_valid && msg_kind != OUT_WB));

    p_write_reply_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == CF_WAIT && reply_ok && cpu_we) |=> (a_st == LS_EXC));

    p_hit_is_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !msg_valid);

    p_fetch_writes_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_act && dir_kind == IN_FETCH && b_owned)
        |-> (msg_valid && msg_kind == OUT_WB && msg_addr == dir_addr));

    p_victim_then_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == CF_MISS && !coh_act && msg_valid && msg_kind == OUT_WB)
        |=> (fsm_q == CF_MISS && a_st == LS_INV));

    p_busy_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != CF_IDLE && cpu_req) |-> cpu_stall);

endmodule

// File: tb/coh_cache_ctrl_tb_top.sv
`timescale 1ns/100ps
module coh_cache_ctrl_tb_top;
    localparam int TAG_W = 4, IDX_W = 2, OFF_W = 1, WORD_W = 8;
    localparam int BA_W = 6, AD_W = 7, BLK_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AD_W-1:0]   cpu_addr = '0;
    logic [WORD_W-1:0] cpu_wdata = '0;
    logic [WORD_W-1:0] cpu_rdata;
    logic              cpu_done, cpu_stall;
    logic              msg_valid;
    logic [1:0]        msg_kind;
    logic [BA_W-1:0]   msg_addr;
    logic [BLK_W-1:0]  msg_blk;
    logic              dir_valid = 1'b0;
    logic [1:0]        dir_kind = '0;
    logic [BA_W-1:0]   dir_addr = '0;
    logic [BLK_W-1:0]  dir_blk = '0;

    coh_cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_blk(msg_blk),
        .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_addr(dir_addr), .dir_blk(dir_blk)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int stall_err = 0;

    // directory model state
    logic [15:0] mem [64];
    logic [1:0]  lg_kind [64];
    logic [5:0]  lg_addr [64];
    logic [15:0] lg_blk  [64];
    int          lg_n = 0;
    int          reply_delay = 0;
    int          inj_seq = 0, inj_ack = 0;
    logic [1:0]  inj_kind = '0;
    logic [5:0]  inj_addr = '0;
    logic [15:0] inj_blk = '0;
    bit          rp_pend = 0;
    int          rp_cnt = 0;
    logic [5:0]  rp_addr = '0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
    end

    always begin
        @(negedge clk);
        dir_valid = 1'b0; dir_kind = '0; dir_addr = '0; dir_blk = '0;
        if (inj_seq != inj_ack) begin
            dir_valid = 1'b1; dir_kind = inj_kind; dir_addr = inj_addr; dir_blk = inj_blk;
            inj_ack = inj_seq;
        end else if (rp_pend) begin
            if (rp_cnt == 0) begin
                dir_valid = 1'b1; dir_kind = 2'd3; dir_addr = rp_addr; dir_blk = mem[rp_addr];
                rp_pend = 0;
            end else rp_cnt--;
        end
        #1;
        if (rst_n && msg_valid) begin
            if (lg_n < 64) begin
                lg_kind[lg_n] = msg_kind; lg_addr[lg_n] = msg_addr; lg_blk[lg_n] = msg_blk;
                lg_n++;
            end
            if (msg_kind == 2'd2) mem[msg_addr] = msg_blk;
            else begin rp_pend = 1; rp_cnt = reply_delay; rp_addr = msg_addr; end
        end
    end

    task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [6:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output int cyc);
        bit got = 0;
        rd = '0; cyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        for (int i = 0; i < 80; i++) begin
            #1;
            if (cpu_done) begin rd = cpu_rdata; got = 1; break; end
            if (!cpu_stall) stall_err++;
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #2;
        if (!got) chk_eq("R9", "completion", 32'd0, 32'd1);
    endtask

    task automatic inject(input logic [1:0] k, input logic [5:0] a, input logic [15:0] d);
        inj_kind = k; inj_addr = a; inj_blk = d;
        inj_seq++;
        @(negedge clk);
        #2;
    endtask

    task automatic chk_msg(input int k, input logic [1:0] kind, input logic [5:0] addr, input string req);
        chk_eq(req, "msg kind", 32'(lg_kind[k]), 32'(kind));
        chk_eq(req, "msg addr", 32'(lg_addr[k]), 32'(addr));
    endtask

    // addresses: A blk 4 (8/9), B blk 8 (16/17), C blk 12 (24/25), X blk 20
    task automatic t_reset();
        chk_eq("R1", "msg_valid after reset", 32'(msg_valid), 32'd0);
        chk_eq("R1", "cpu_stall after reset", 32'(cpu_stall), 32'd0);
    endtask

    task automatic t_read_miss();
        logic [7:0] rd; int cyc; int m = lg_n;
        access(1'b0, 7'd9, 8'h00, rd, cyc);
        chk_eq("R1", "first access messages", 32'(lg_n - m), 32'd1);
        chk_msg(m, 2'd0, 6'd4, "R2");
        chk_eq("R2", "read miss data", 32'(rd), 32'hA1);
        chk_eq("R9", "read miss cycles", 32'(cyc), 32'd3);
    endtask

    task automatic t_read_hit();
        logic [7:0] rd; int cyc; int m = lg_n;
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R4", "read hit messages", 32'(lg_n - m), 32'd0);
        chk_eq("R4", "read hit data", 32'(rd), 32'h04);
        chk_eq("R4", "read hit cycles", 32'(cyc), 32'd0);
    endtask

    task automatic t_write_shared();
        logic [7:0] rd; int cyc; int m = lg_n;
        access(1'b1, 7'd8, 8'h3C, rd, cyc);
        chk_eq("R3", "write on shared messages", 32'(lg_n - m), 32'd1);
        chk_msg(m, 2'd1, 6'd4, "R3");
        access(1'b0, 7'd9, 8'h00, rd, cyc);
        chk_eq("R3", "merged other word", 32'(rd), 32'hA1);
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R3", "merged written word", 32'(rd), 32'h3C);
        chk_eq("R3", "no further messages", 32'(lg_n - m), 32'd1);
    endtask

    task automatic t_write_hit();
        logic [7:0] rd; int cyc; int m = lg_n;
        access(1'b1, 7'd9, 8'h77, rd, cyc);
        chk_eq("R4", "write hit messages", 32'(lg_n - m), 32'd0);
        chk_eq("R4", "write hit cycles", 32'(cyc), 32'd0);
    endtask

    task automatic t_fetch();
        logic [7:0] rd; int cyc; int m = lg_n;
        inject(2'd1, 6'd4, 16'h0);
        chk_eq("R6", "fetch messages", 32'(lg_n - m), 32'd1);
        chk_msg(m, 2'd2, 6'd4, "R6");
        chk_eq("R6", "fetch data", 32'(lg_blk[m]), 32'h773C);
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R6", "read after fetch is hit", 32'(lg_n - m), 32'd1);
        chk_eq("R6", "read after fetch data", 32'(rd), 32'h3C);
        access(1'b1, 7'd8, 8'h11, rd, cyc);
        chk_eq("R6", "write after fetch misses", 32'(lg_n - m), 32'd2);
        chk_msg(m + 1, 2'd1, 6'd4, "R6");
    endtask

    task automatic t_fetchinv();
        logic [7:0] rd; int cyc; int m = lg_n;
        inject(2'd2, 6'd4, 16'h0);
        chk_msg(m, 2'd2, 6'd4, "R7");
        chk_eq("R7", "fetch-inv data", 32'(lg_blk[m]), 32'h7711);
        access(1'b0, 7'd9, 8'h00, rd, cyc);
        chk_eq("R7", "read after fetch-inv misses", 32'(lg_n - m), 32'd2);
        chk_msg(m + 1, 2'd0, 6'd4, "R7");
        chk_eq("R7", "refetched data", 32'(rd), 32'h77);
    endtask

    task automatic t_inval();
        logic [7:0] rd; int cyc; int m = lg_n;
        inject(2'd0, 6'd4, 16'h0);
        chk_eq("R5", "invalidate is silent", 32'(lg_n - m), 32'd0);
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R5", "read after invalidate misses", 32'(lg_n - m), 32'd1);
        chk_msg(m, 2'd0, 6'd4, "R5");
        chk_eq("R5", "read data", 32'(rd), 32'h11);
    endtask

    task automatic t_ignore();
        logic [7:0] rd; int cyc; int m = lg_n;
        inject(2'd0, 6'd20, 16'h0);
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R10", "wrong-tag invalidate ignored", 32'(lg_n - m), 32'd0);
        chk_eq("R10", "data kept", 32'(rd), 32'h11);
        access(1'b1, 7'd8, 8'h22, rd, cyc);
        m = lg_n;
        inject(2'd1, 6'd20, 16'h0);
        inject(2'd2, 6'd20, 16'h0);
        inject(2'd3, 6'd4, 16'hFFFF);
        chk_eq("R10", "wrong-tag fetches silent", 32'(lg_n - m), 32'd0);
        access(1'b0, 7'd8, 8'h00, rd, cyc);
        chk_eq("R10", "stray reply ignored", 32'(rd), 32'h22);
        chk_eq("R10", "still exclusive hit", 32'(cyc), 32'd0);
    endtask

    task automatic t_victim();
        logic [7:0] rd; int cyc; int m = lg_n;
        access(1'b0, 7'd17, 8'h00, rd, cyc);
        chk_eq("R8", "victim message count", 32'(lg_n - m), 32'd2);
        chk_msg(m, 2'd2, 6'd4, "R8");
        chk_eq("R8", "victim data", 32'(lg_blk[m]), 32'h7722);
        chk_msg(m + 1, 2'd0, 6'd8, "R8");
        chk_eq("R8", "new block data", 32'(rd), 32'hAD);
        chk_eq("R9", "victim miss cycles", 32'(cyc), 32'd4);
        m = lg_n;
        access(1'b0, 7'd9, 8'h00, rd, cyc);
        chk_eq("R8", "shared victim dropped", 32'(lg_n - m), 32'd1);
        chk_msg(m, 2'd0, 6'd4, "R8");
        chk_eq("R8", "written-back data reread", 32'(rd), 32'h77);
    endtask

    task automatic t_write_victim();
        logic [7:0] rd; int cyc; int m;
        access(1'b1, 7'd8, 8'h55, rd, cyc);
        m = lg_n;
        access(1'b1, 7'd24, 8'h66, rd, cyc);
        chk_eq("R8", "write victim count", 32'(lg_n - m), 32'd2);
        chk_msg(m, 2'd2, 6'd4, "R8");
        chk_eq("R8", "write victim data", 32'(lg_blk[m]), 32'h7755);
        chk_msg(m + 1, 2'd1, 6'd12, "R3");
        access(1'b0, 7'd25, 8'h00, rd, cyc);
        chk_eq("R3", "merge kept replied word", 32'(rd), 32'hA9);
    endtask

    task automatic t_slow_reply();
        logic [7:0] rd; int cyc; int m = lg_n;
        reply_delay = 4;
        access(1'b0, 7'd16, 8'h00, rd, cyc);
        reply_delay = 0;
        chk_eq("R9", "slow reply cycles", 32'(cyc), 32'd8);
        chk_eq("R8", "slow victim data", 32'(lg_blk[m]), 32'hA966);
        chk_msg(m + 1, 2'd0, 6'd8, "R2");
        chk_eq("R2", "slow reply data", 32'(rd), 32'h08);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_shared();
        t_write_hit();
        t_fetch();
        t_fetchinv();
        t_inval();
        t_ignore();
        t_victim();
        t_write_victim();
        t_slow_reply();
        chk_eq("R9", "stall low while pending", 32'(stall_err), 32'd0);
        finish_run();
    end

endmodule